// File: doc/BRIEF.md
# Four-Way Pseudo-LRU Victim Selector

This block holds the replacement history of a four-way set-associative cache and names the way that a miss should fill. Every set keeps three tree bits. A root bit picks one of two pairs of ways, and one bit inside each pair picks a way of that pair. If the addressed set still has an empty way, that empty way is the victim and the tree bits are not used. A hit or a fill marks the touched way as recently used by moving the tree bits away from it.

The same block decides whether a miss may allocate at all. A fill is allowed only when the per-page no-cache flag is clear and the active-low external cache-enable input is asserted (low). The per-page write-through flag plays no part in this decision and is only carried through to an output. The victim output is combinational from the addressed set's state. Tree updates land on the clock edge that ends an access cycle. A synchronous invalidate strobe clears every set's tree.

Top module: `plru4_victim_sel`

## Requirements
- R1: When at least one bit of `way_valid` is 0, `victim_way` is the lowest-numbered way whose valid bit is 0 (bit i of `way_valid` belongs to way i, and `victim_way` is the way number in binary).
- R2: When all four ways are valid, root bit B0=0 makes the victim come from ways 0/1 and B0=1 makes it come from ways 2/3.
- R3: Within ways 0/1, pair bit B1=0 selects way 0 and B1=1 selects way 1.
- R4: Within ways 2/3, pair bit B2=0 selects way 2 and B2=1 selects way 3.
- R5: `fill_ok` is 1 only when `page_nocache` is 0 and `ext_cache_en_n` is 0.
- R6: `wthru_out` always equals `page_wthru`, and `page_wthru` has no effect on `fill_ok`, `victim_way` or the tree state.
- R7: An access with `hit`=1 updates the addressed set: way 0 sets B0=1 and B1=1, way 1 sets B0=1 and B1=0, way 2 sets B0=0 and B2=1, way 3 sets B0=0 and B2=0. The remaining bit is unchanged.
- R8: A miss with `fill_ok`=1 applies the R7 update for the way that `victim_way` names in that cycle.
- R9: A miss with `fill_ok`=0 leaves the set's tree bits unchanged.
- R10: Reset (`rst_n`=0) or `inv_all`=1 at a clock edge clears all tree bits of every set to 0. The invalidate takes priority over an access in the same cycle.
- R11: An update becomes visible on `victim_way` in the cycle after the access strobe, and it changes only the set addressed by `set_idx`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| inv_all | input | 1 | Clear the tree bits of every set at the next edge |
| set_idx | input | SET_W | Set addressed this cycle |
| way_valid | input | 4 | Valid bit of each way in the addressed set |
| acc_vld | input | 1 | An access to the addressed set happens this cycle |
| hit | input | 1 | The access hit (1) or missed (0) |
| hit_way | input | 2 | Way that hit, used when `hit`=1 |
| page_nocache | input | 1 | Page-level cache-disable flag, 1 forbids fills |
| ext_cache_en_n | input | 1 | External cache enable, active low |
| page_wthru | input | 1 | Page-level write-through flag |
| victim_way | output | 2 | Way to replace on a miss |
| fill_ok | output | 1 | A miss may allocate |
| wthru_out | output | 1 | Copy of `page_wthru` |

## Verification
The assertions take for granted that `hit_way` names a way only when `hit` is 1 and that `set_idx` stays inside the configured number of sets. They also assume the control inputs are stable from one clock edge to the next. Properties that compare the tree across an edge accept a change of `set_idx`, because the tree read then comes from another set. The stimulus drives every input on the falling edge and keeps `acc_vld` high for exactly one cycle. It uses only set indices below the set count, so all three assumptions hold throughout.

// File: rtl/plru4_pkg.sv
// Shared types for the four-way pseudo-LRU selector.
// Assumes exactly four ways; the tree layout depends on it.
package plru4_pkg;
    typedef logic [1:0] way_t;

    // b0 chooses the pair, b1 orders ways 0/1, b2 orders ways 2/3
    typedef struct packed {
        logic b2;
        logic b1;
        logic b0;
    } tree_t;
endpackage

// File: rtl/plru4_tree_store.sv
// Per-set storage of the three tree bits.
// One write port, one combinational read port. Reset or clear empties
// all sets. Assumes NUM_SETS is a power of two so every index is in range.
module plru4_tree_store
    import plru4_pkg::*;
#(
    parameter int NUM_SETS = 64,
    localparam int SET_W   = $clog2(NUM_SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_all,
    input  logic             wr_en,
    input  logic [SET_W-1:0] wr_idx,
    input  tree_t            wr_tree,
    input  logic [SET_W-1:0] rd_idx,
    output tree_t            rd_tree
);
    tree_t mem [NUM_SETS];

    // State update: a clear beats a write
    always_ff @(posedge clk) begin
        if (!rst_n || clr_all) begin
            for (int i = 0; i < NUM_SETS; i++) begin
                mem[i] <= '0;
            end
        end else if (wr_en) begin
            mem[wr_idx] <= wr_tree;
        end
    end

    // Read port for the addressed set
    always_comb begin
        rd_tree = mem[rd_idx];
    end
endmodule

// File: rtl/plru4_victim_pick.sv
// Victim choice for one set. An empty way wins first, lowest number
// first. With all ways full the tree bits decide. Purely combinational.
module plru4_victim_pick
    import plru4_pkg::*;
(
    input  logic [3:0] valid,
    input  tree_t      tree,
    output way_t       victim
);
    logic any_empty;
    way_t first_empty;
    way_t tree_pick;

    // Lowest-numbered empty way
    always_comb begin
        any_empty   = ~&valid;
        first_empty = '0;
        for (int i = 3; i >= 0; i--) begin
            if (!valid[i]) first_empty = way_t'(i);
        end
    end

    // Walk of the tree: root picks the pair, the pair bit picks the way
    always_comb begin
        if (tree.b0) tree_pick = tree.b2 ? 2'd3 : 2'd2;
        else         tree_pick = tree.b1 ? 2'd1 : 2'd0;
    end

    // An empty way overrides the tree
    always_comb begin
        victim = any_empty ? first_empty : tree_pick;
    end
endmodule

// File: rtl/plru4_tree_next.sv
// Next tree state after a way is used: the bits are pointed away
// from the used way. The bit of the other pair is kept.
module plru4_tree_next
    import plru4_pkg::*;
(
    input  tree_t cur,
    input  way_t  used,
    output tree_t nxt
);
    // Move the path away from the used way
    always_comb begin
        nxt = cur;
        unique case (used)
            2'd0: begin nxt.b0 = 1'b1; nxt.b1 = 1'b1; end
            2'd1: begin nxt.b0 = 1'b1; nxt.b1 = 1'b0; end
            2'd2: begin nxt.b0 = 1'b0; nxt.b2 = 1'b1; end
            default: begin nxt.b0 = 1'b0; nxt.b2 = 1'b0; end
        endcase
    end
endmodule

// File: rtl/plru4_fill_gate.sv
// Cacheability gate. A fill needs the page flag clear and the
// active-low external enable low. The write-through flag only passes on.
module plru4_fill_gate (
    input  logic page_nocache,
    input  logic ext_cache_en_n,
    input  logic page_wthru,
    output logic fill_ok,
    output logic wthru_out
);
    // Both signals must permit the fill (a NOR of the two)
    always_comb begin
        fill_ok   = ~(page_nocache | ext_cache_en_n);
        wthru_out = page_wthru;
    end
endmodule

// File: rtl/plru4_victim_sel.sv
// Four-way pseudo-LRU victim selector, top level.
// Reads the addressed set's tree and names a victim. Updates the tree
// on a hit, or on a miss that may fill. Assumes hit_way is meaningful
// only with hit=1 and that set_idx is below NUM_SETS.
module plru4_victim_sel
    import plru4_pkg::*;
#(
    parameter int NUM_SETS = 64,
    localparam int SET_W   = $clog2(NUM_SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inv_all,
    input  logic [SET_W-1:0] set_idx,
    input  logic [3:0]       way_valid,
    input  logic             acc_vld,
    input  logic             hit,
    input  logic [1:0]       hit_way,
    input  logic             page_nocache,
    input  logic             ext_cache_en_n,
    input  logic             page_wthru,
    output logic [1:0]       victim_way,
    output logic             fill_ok,
    output logic             wthru_out
);
    tree_t cur_tree;
    tree_t new_tree;
    way_t  pick;
    way_t  used_way;
    logic  upd_en;

    plru4_fill_gate u_gate (
        .page_nocache   (page_nocache),
        .ext_cache_en_n (ext_cache_en_n),
        .page_wthru     (page_wthru),
        .fill_ok        (fill_ok),
        .wthru_out      (wthru_out)
    );

    plru4_victim_pick u_pick (
        .valid  (way_valid),
        .tree   (cur_tree),
        .victim (pick)
    );

    // Way to mark as used and whether the tree moves at all
    always_comb begin
        used_way   = hit ? way_t'(hit_way) : pick;
        upd_en     = acc_vld & (hit | fill_ok);
        victim_way = pick;
    end

    plru4_tree_next u_next (
        .cur  (cur_tree),
        .used (used_way),
        .nxt  (new_tree)
    );

    plru4_tree_store #(.NUM_SETS(NUM_SETS)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_all (inv_all),
        .wr_en   (upd_en),
        .wr_idx  (set_idx),
        .wr_tree (new_tree),
        .rd_idx  (set_idx),
        .rd_tree (cur_tree)
    );

    // R1: with an empty way present the victim is empty
    a_r1_empty_victim: assert property (@(posedge clk) disable iff (!rst_n)
        (way_valid != 4'hF) |-> !way_valid[victim_way]);

    // R2: root bit 0 with all ways full keeps the victim in ways 0/1
    a_r2_low_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (way_valid == 4'hF && !cur_tree.b0) |-> !victim_way[1]);

    // R7: a hit on way 0 leaves b0 and b1 set in the next cycle
    a_r7_hit_way0: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_vld && hit && hit_way == 2'd0 && !inv_all) |=>
        (set_idx != $past(set_idx)) || (cur_tree.b0 && cur_tree.b1));

    // R9: a miss that may not fill keeps the tree
    a_r9_nocache_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_vld && !hit && !fill_ok && !inv_all) |=>
        (set_idx != $past(set_idx)) || (cur_tree == $past(cur_tree)));

    // R10: after an invalidate every set reads as cleared
    a_r10_inv_clears: assert property (@(posedge clk) disable iff (!rst_n)
        inv_all |=> (cur_tree == '0));

    // R5: a fill is never allowed against either cacheability signal
    a_r5_fill_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (page_nocache || ext_cache_en_n) |-> !fill_ok);
endmodule

// File: tb/tb_plru4_victim_sel.sv
module tb_plru4_victim_sel;
    localparam int NUM_SETS = 64;
    localparam int SET_W    = $clog2(NUM_SETS);

    logic             clk = 1'b0;
    logic             rst_n;
    logic             inv_all;
    logic [SET_W-1:0] set_idx;
    logic [3:0]       way_valid;
    logic             acc_vld;
    logic             hit;
    logic [1:0]       hit_way;
    logic             page_nocache;
    logic             ext_cache_en_n;
    logic             page_wthru;
    logic [1:0]       victim_way;
    logic             fill_ok;
    logic             wthru_out;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // model tree per set: bit0=b0, bit1=b1, bit2=b2
    logic [2:0] mdl [NUM_SETS];

    plru4_victim_sel #(.NUM_SETS(NUM_SETS)) dut (
        .clk(clk), .rst_n(rst_n), .inv_all(inv_all), .set_idx(set_idx),
        .way_valid(way_valid), .acc_vld(acc_vld), .hit(hit), .hit_way(hit_way),
        .page_nocache(page_nocache), .ext_cache_en_n(ext_cache_en_n),
        .page_wthru(page_wthru), .victim_way(victim_way), .fill_ok(fill_ok),
        .wthru_out(wthru_out)
    );

    always #4 clk = ~clk;   // 125 MHz

    function automatic logic [1:0] exp_victim(logic [3:0] v, logic [2:0] t);
        for (int i = 0; i < 4; i++) if (!v[i]) return 2'(i);
        if (t[0]) return t[2] ? 2'd3 : 2'd2;
        return t[1] ? 2'd1 : 2'd0;
    endfunction

    function automatic logic [2:0] exp_next(logic [2:0] t, logic [1:0] w);
        logic [2:0] n = t;
        case (w)
            2'd0: begin n[0] = 1; n[1] = 1; end
            2'd1: begin n[0] = 1; n[1] = 0; end
            2'd2: begin n[0] = 0; n[2] = 1; end
            default: begin n[0] = 0; n[2] = 0; end
        endcase
        return n;
    endfunction

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic mdl_clear();
        for (int i = 0; i < NUM_SETS; i++) mdl[i] = 3'b000;
    endtask

    // one-cycle access; model follows the requirements
    task automatic access(int s, logic [3:0] v, logic h, logic [1:0] hw,
                          logic nc, logic en_n);
        @(negedge clk);
        set_idx = SET_W'(s); way_valid = v; hit = h; hit_way = hw;
        page_nocache = nc; ext_cache_en_n = en_n; acc_vld = 1;
        if (h) mdl[s] = exp_next(mdl[s], hw);
        else if (!nc && !en_n) mdl[s] = exp_next(mdl[s], exp_victim(v, mdl[s]));
        @(negedge clk);
        acc_vld = 0; hit = 0; page_nocache = 0; ext_cache_en_n = 0;
    endtask

    // observe a set with all ways valid
    task automatic probe(int s, string req);
        set_idx = SET_W'(s); way_valid = 4'hF;
        #1;
        chk(req, victim_way, exp_victim(4'hF, mdl[s]));
    endtask

    task automatic t_reset();
        mdl_clear();
        for (int s = 0; s < NUM_SETS; s += 9) probe(s, "R10 reset");
    endtask

    task automatic t_empty_pref();
        logic [3:0] pats [6] = '{4'b1110, 4'b1101, 4'b0011, 4'b0111, 4'b0101, 4'b1011};
        logic [1:0] exps [6] = '{2'd0, 2'd1, 2'd2, 2'd3, 2'd1, 2'd2};
        access(7, 4'hF, 1, 2'd0, 0, 0);   // tree points away from way 0/1 pair
        for (int i = 0; i < 6; i++) begin
            set_idx = 6'd7; way_valid = pats[i];
            #1;
            chk("R1 empty way first", victim_way, exps[i]);
        end
    endtask

    task automatic t_tree_walk();
        access(1, 4'hF, 1, 2'd0, 0, 0); probe(1, "R2 R4 after hit way0");
        chk("R4 b2=0 -> way2", victim_way, 2);
        access(1, 4'hF, 1, 2'd2, 0, 0); probe(1, "R2 R3 after hit way2");
        chk("R3 b1=1 -> way1", victim_way, 1);
        access(1, 4'hF, 1, 2'd1, 0, 0); probe(1, "R7 after hit way1");
        chk("R4 b2=1 -> way3", victim_way, 3);
        access(1, 4'hF, 1, 2'd3, 0, 0); probe(1, "R7 after hit way3");
        chk("R3 b1=0 -> way0", victim_way, 0);
    endtask

    task automatic t_fill();
        access(2, 4'b1011, 0, 2'd0, 0, 0);   // fills way2
        probe(2, "R8 fill into empty way2");
        access(2, 4'hF, 0, 2'd0, 0, 0);      // fills tree victim
        probe(2, "R8 fill from tree");
    endtask

    task automatic t_nocache();
        for (int c = 0; c < 4; c++) begin
            page_nocache = c[0]; ext_cache_en_n = c[1];
            #1;
            chk("R5 fill gate", fill_ok, (c == 0) ? 1 : 0);
        end
        page_nocache = 0; ext_cache_en_n = 0;
        access(3, 4'hF, 1, 2'd1, 0, 0);
        access(3, 4'hF, 0, 2'd0, 1, 0);
        probe(3, "R9 miss page no-cache");
        access(3, 4'b0111, 0, 2'd0, 0, 1);
        probe(3, "R9 miss ext disabled");
    endtask

    task automatic t_wthru();
        access(4, 4'hF, 1, 2'd2, 0, 0);
        for (int w = 0; w < 2; w++) begin
            page_wthru = w[0];
            #1;
            chk("R6 wthru pass", wthru_out, w);
            chk("R6 fill_ok unaffected", fill_ok, 1);
            probe(4, "R6 victim unaffected");
        end
        @(negedge clk);
        page_wthru = 1;
        access(4, 4'hF, 0, 2'd0, 0, 0);
        page_wthru = 0;
        probe(4, "R6 update unaffected");
    endtask

    task automatic t_invalidate();
        access(10, 4'hF, 1, 2'd0, 0, 0);
        access(11, 4'hF, 1, 2'd3, 0, 0);
        @(negedge clk);
        inv_all = 1; acc_vld = 1; hit = 1; hit_way = 2'd0; set_idx = 6'd10;
        @(negedge clk);
        inv_all = 0; acc_vld = 0; hit = 0;
        mdl_clear();
        probe(10, "R10 invalidate beats access");
        probe(11, "R10 invalidate other set");
    endtask

    task automatic t_timing();
        mdl_clear();
        @(negedge clk);
        set_idx = 6'd5; way_valid = 4'hF; hit = 1; hit_way = 2'd0; acc_vld = 1;
        #1;
        chk("R11 old state during access", victim_way, 0);
        @(negedge clk);
        acc_vld = 0; hit = 0;
        mdl[5] = exp_next(mdl[5], 2'd0);
        probe(5, "R11 new state next cycle");
        chk("R11 next-cycle value", victim_way, 2);
        probe(6, "R11 other set untouched");
        chk("R11 other set way0", victim_way, 0);
    endtask

    initial begin
        rst_n = 0; inv_all = 0; set_idx = '0; way_valid = 4'hF; acc_vld = 0;
        hit = 0; hit_way = '0; page_nocache = 0; ext_cache_en_n = 0; page_wthru = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_empty_pref();
        t_tree_walk();
        t_fill();
        t_nocache();
        t_wthru();
        t_invalidate();
        t_timing();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule